// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Protocol Engine

This block is the protocol front end of a byte-addressed 64K x 8 serial memory on a two-wire bus. It synchronises the bus clock and data lines into the system clock domain and finds START and STOP conditions on those synchronised copies. It shifts bytes in MSB first and checks the first byte of each transfer against a fixed device type code and three strap inputs. It then takes a two-byte memory address and answers each byte in the ninth clock slot by pulling the data line low through an open-drain enable.

Data bytes go to the storage side as single-cycle write strobes. The address steps within a 128-byte page. A STOP that follows accepted data produces a commit pulse, which starts the programming cycle. Reads go out as single-cycle requests. The requested byte is shifted onto the bus MSB first, and the master's acknowledge decides whether the next byte follows. A write-protect input refuses data bytes but leaves selection and addressing untouched. While the storage side reports a programming cycle in progress, the engine ignores the bus completely.

Top module: `i2cs_engine`

## Requirements
- R1: After reset the open-drain enable is low, no write, commit or read strobe is active, and the engine waits for a START.
- R2: START is the data line falling while the clock line is high, and STOP is the data line rising while the clock line is high. A START at any point, including in the middle of a byte, drops the partial byte and begins a new select byte.
- R3: The select byte is taken MSB first. Bits 7..4 must be 1010 and bits 3..1 must equal strap_i[2], strap_i[1], strap_i[0]. Bit 0 is the direction, with 1 for read and 0 for write. On a match the engine acknowledges in the ninth slot. On a mismatch it acknowledges nothing until the next START.
- R4: After a write select, the engine takes two address bytes, high byte (bits 15..8) first and then low byte (bits 7..0), and acknowledges each one. This address is where the next write or read starts.
- R5: With wp_i low, each data byte is acknowledged and produces one wr_en_o pulse carrying the current address and the byte. The address then advances in its low 7 bits only, so it wraps inside its 128-byte page.
- R6: With wp_i high, the select and address bytes are still acknowledged. Every data byte gets no acknowledge, produces no write strobe and leaves the address unchanged.
- R7: A STOP received during a write that accepted at least one data byte produces exactly one wr_commit_o pulse. A write that accepted no data produces none.
- R8: On a read, rd_req_o pulses with rd_addr_o. The byte on rd_data_i one cycle later is shifted out MSB first, and the address advances across all 16 bits, so it does not wrap at a page. A master acknowledge gets the next byte. A master no-acknowledge sends the engine to standby, where it leaves the bus released.
- R9: A read that follows a select with no address bytes starts at the address that the previous access left behind.
- R10: While busy_i is high the engine keeps the data line released, acknowledges nothing, ignores START and produces no strobes.
- R11: The open-drain enable changes only while the synchronised clock line is low, except when busy_i forces it off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (resolved wired-AND value) |
| strap_i | input | 3 | Device select strap bits, compared with select bits 3..1 |
| wp_i | input | 1 | Write protect; high refuses data bytes |
| busy_i | input | 1 | Programming cycle in progress; bus ignored |
| rd_data_i | input | 8 | Read byte, valid from the cycle after rd_req_o |
| sda_oe_o | output | 1 | High pulls the data line low |
| wr_en_o | output | 1 | Single-cycle write strobe |
| wr_addr_o | output | 16 | Write address |
| wr_data_o | output | 8 | Write byte |
| wr_commit_o | output | 1 | Pulse on STOP after accepted write data |
| rd_req_o | output | 1 | Single-cycle read request |
| rd_addr_o | output | 16 | Read address |

## Verification
The bench writes runs of bytes that cross the end of a 128-byte page. A design that carried the increment into bit 7 would write the following page instead of wrapping. Read-back runs cross the same boundary, which catches an engine that wrapped read addresses as well. It sends select bytes with a wrong type code and with a wrong strap, and checks both for no acknowledge. It runs write-protected transfers, where acknowledging the data, or skipping the acknowledge on the address, shows up at the bus. It also checks that a protected transfer leaves memory and the commit count unchanged. Further runs test a START that cuts a byte in half, a select sent while busy_i is high, and a clock-out after the master's no-acknowledge, where a correct engine returns all ones.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int ADDR_W   = 16;
    localparam int PAGE_W   = 7;
    localparam int BYTE_W   = 8;
    localparam int STRAP_W  = 3;
    localparam int CNT_W    = 4;

    localparam logic [3:0]       TYPE_CODE = 4'b1010;
    localparam logic [CNT_W-1:0] CNT_ACK   = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_SLOT  = CNT_W'(BYTE_W + 1);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_WR,
        PH_RD
    } phase_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } wr_beat_t;

    function automatic logic sel_match(input logic [BYTE_W-1:0] b,
                                       input logic [STRAP_W-1:0] s);
        return (b[7:4] == TYPE_CODE) && (b[3:1] == s);
    endfunction

    function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] m;
        logic [ADDR_W-1:0] inc;
        m   = {{(ADDR_W-PAGE_W){1'b0}}, {PAGE_W{1'b1}}};
        inc = a + 1'b1;
        return (a & ~m) | (inc & m);
    endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar g = 0; g < STAGES; g++) begin : g_st
        logic [W-1:0] q;
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) q <= '1;
                else     q <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) q <= '1;
                else     q <= g_st[g-1].q;
            end
        end
    end

    assign dout = g_st[STAGES-1].q;
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
    input  logic clk,
    input  logic rst,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    always_comb begin
        scl_rise = scl_s & ~scl_p;
        scl_fall = ~scl_s & scl_p;
        start_c  = scl_s & scl_p & sda_p & ~sda_s;
        stop_c   = scl_s & scl_p & ~sda_p & sda_s;
    end

    AST_START_CLOCK_HIGH: assert property (@(posedge clk) disable iff (rst)
        start_c |-> (scl_s && !scl_rise)); // R2
endmodule

// File: rtl/i2cs_byte.sv
module i2cs_byte
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              load,
    input  logic              arm_ack,
    input  logic              shift,
    input  logic              in_bit,
    input  logic [BYTE_W-1:0] load_val,
    output logic [CNT_W-1:0]  cnt,
    output logic [BYTE_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            data <= '0;
        end else if (clr) begin
            cnt  <= '0;
        end else if (load) begin
            cnt  <= '0;
            data <= load_val;
        end else if (arm_ack) begin
            cnt  <= CNT_SLOT;
        end else if (shift) begin
            cnt  <= cnt + 1'b1;
            data <= {data[BYTE_W-2:0], in_bit};
        end
    end

    AST_CNT_LEGAL: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_SLOT); // R2
    AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        (load && !clr) |=> (cnt == '0)); // R8
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               wp_i,
    input  logic               busy_i,
    input  logic [BYTE_W-1:0]  rd_data_i,
    output logic               sda_oe_o,
    output logic               wr_en_o,
    output logic [ADDR_W-1:0]  wr_addr_o,
    output logic [BYTE_W-1:0]  wr_data_o,
    output logic               wr_commit_o,
    output logic               rd_req_o,
    output logic [ADDR_W-1:0]  rd_addr_o
);
    logic [1:0] lines_s;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_c, stop_c;

    i2cs_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({scl_i, sda_i}),
        .dout (lines_s)
    );
    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    i2cs_cond u_cond (
        .clk      (clk),
        .rst      (rst),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c)
    );

    phase_t             phase, nxt_ph;
    logic [ADDR_W-1:0]  addr;
    logic               oe, wr_pend;
    wr_beat_t           beat;
    logic               wr_en_r, commit_r, rd_req_r;
    logic [CNT_W-1:0]   bit_cnt;
    logic [BYTE_W-1:0]  sh;
    logic               live, ack_start, ack_end;
    logic               br_clr, br_load, br_arm, br_shift;

    always_comb begin
        live      = !busy_i && !start_c && !stop_c && (phase != PH_IDLE);
        ack_start = live && scl_fall && (bit_cnt == CNT_ACK);
        ack_end   = live && scl_fall && (bit_cnt == CNT_SLOT);
        br_shift  = live && scl_rise && (bit_cnt < CNT_ACK);
        br_arm    = ack_start;
        br_load   = ack_end && (nxt_ph == PH_RD);
        br_clr    = start_c || (ack_end && (nxt_ph != PH_RD));
    end

    i2cs_byte u_byte (
        .clk      (clk),
        .rst      (rst),
        .clr      (br_clr),
        .load     (br_load),
        .arm_ack  (br_arm),
        .shift    (br_shift),
        .in_bit   (sda_s),
        .load_val (rd_data_i),
        .cnt      (bit_cnt),
        .data     (sh)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            nxt_ph   <= PH_IDLE;
            addr     <= '0;
            oe       <= 1'b0;
            wr_pend  <= 1'b0;
            beat     <= '0;
            wr_en_r  <= 1'b0;
            commit_r <= 1'b0;
            rd_req_r <= 1'b0;
        end else begin
            wr_en_r  <= 1'b0;
            commit_r <= 1'b0;
            rd_req_r <= 1'b0;
            if (busy_i) begin
                phase   <= PH_IDLE;
                oe      <= 1'b0;
                wr_pend <= 1'b0;
            end else if (start_c) begin
                phase   <= PH_DEV;
                oe      <= 1'b0;
                wr_pend <= 1'b0;
            end else if (stop_c) begin
                commit_r <= (phase == PH_WR) && wr_pend;
                phase    <= PH_IDLE;
                oe       <= 1'b0;
                wr_pend  <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (ack_start) begin
                    unique case (phase)
                        PH_DEV: begin
                            if (sel_match(sh, strap_i)) begin
                                oe       <= 1'b1;
                                nxt_ph   <= sh[0] ? PH_RD : PH_AHI;
                                rd_req_r <= sh[0];
                            end else begin
                                oe    <= 1'b0;
                                phase <= PH_IDLE;
                            end
                        end
                        PH_AHI: begin
                            addr[ADDR_W-1 -: BYTE_W] <= sh;
                            oe     <= 1'b1;
                            nxt_ph <= PH_ALO;
                        end
                        PH_ALO: begin
                            addr[BYTE_W-1:0] <= sh;
                            oe     <= 1'b1;
                            nxt_ph <= PH_WR;
                        end
                        PH_WR: begin
                            nxt_ph <= PH_WR;
                            if (!wp_i) begin
                                oe        <= 1'b1;
                                wr_en_r   <= 1'b1;
                                beat.addr <= addr;
                                beat.data <= sh;
                                addr      <= page_next(addr);
                                wr_pend   <= 1'b1;
                            end else begin
                                oe <= 1'b0;
                            end
                        end
                        PH_RD: begin
                            oe       <= 1'b0;
                            nxt_ph   <= PH_RD;
                            rd_req_r <= 1'b1;
                        end
                        default: oe <= 1'b0;
                    endcase
                end else if (ack_end) begin
                    phase <= nxt_ph;
                    if (nxt_ph == PH_RD) begin
                        oe   <= ~rd_data_i[BYTE_W-1];
                        addr <= addr + 1'b1;
                    end else begin
                        oe <= 1'b0;
                    end
                end else if (scl_rise && (bit_cnt == CNT_SLOT) && (phase == PH_RD) && sda_s) begin
                    nxt_ph <= PH_IDLE;
                end else if (scl_fall && (phase == PH_RD) &&
                             (bit_cnt inside {[4'd1:4'd7]})) begin
                    oe <= ~sh[BYTE_W-1];
                end
            end
        end
    end

    assign sda_oe_o    = oe;
    assign wr_en_o     = wr_en_r;
    assign wr_addr_o   = beat.addr;
    assign wr_data_o   = beat.data;
    assign wr_commit_o = commit_r;
    assign rd_req_o    = rd_req_r;
    assign rd_addr_o   = addr;

    AST_OE_CLOCK_LOW: assert property (@(posedge clk) disable iff (rst)
        (!$stable(oe) && !$past(busy_i)) |-> !scl_s); // R11
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(busy_i) |-> (!oe && !wr_en_r && !rd_req_r)); // R10
    AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        wr_en_r |-> !$past(wp_i)); // R6
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_en_r, rd_req_r, commit_r})); // R5
    AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (rst)
        commit_r |-> $past(stop_c)); // R7
endmodule

// File: tb/i2cs_engine_test.sv
`timescale 1ns/1ps
module i2cs_engine_test;
    localparam int Q = 8;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] SEL_W = 8'hAA;
    localparam logic [7:0] SEL_R = 8'hAB;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1, sda_m = 1'b1;
    logic        wp_i = 1'b0, busy_i = 1'b0;
    logic [7:0]  rd_data = 8'h00;
    logic        sda_oe_o, wr_en_o, wr_commit_o, rd_req_o;
    logic [15:0] wr_addr_o, rd_addr_o;
    logic [7:0]  wr_data_o;
    logic        sda_line;

    int checks = 0, errors = 0, commits = 0, oe_bad = 0;
    logic oe_prev = 1'b0;
    bit   done = 1'b0;
    logic [7:0] dut_mem [int];
    logic [7:0] exp_mem [int];
    logic [15:0] exp_addr = 16'h0000;

    always #2 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe_o;

    i2cs_engine uut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .strap_i(STRAP), .wp_i(wp_i), .busy_i(busy_i), .rd_data_i(rd_data),
        .sda_oe_o(sda_oe_o), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o), .wr_commit_o(wr_commit_o),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o)
    );

    function automatic logic [7:0] dflt(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5C;
    endfunction
    function automatic logic [7:0] get_exp(input logic [15:0] a);
        return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : dflt(a);
    endfunction
    function automatic logic [7:0] get_dut(input logic [15:0] a);
        return dut_mem.exists(int'(a)) ? dut_mem[int'(a)] : dflt(a);
    endfunction

    // storage-side model
    always @(posedge clk) begin
        if (wr_en_o) dut_mem[int'(wr_addr_o)] = wr_data_o;
        if (rd_req_o) rd_data <= get_dut(rd_addr_o);
        if (wr_commit_o) commits++;
        if (!rst && (sda_oe_o != oe_prev) && scl_m && !busy_i) oe_bad++;
        oe_prev <= sda_oe_o;
    end

    task automatic check(input string r, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic v);
        sda_m = b; wait_q();
        scl_m = 1'b1; wait_q();
        v = sda_line;
        scl_m = 1'b0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic v;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], v);
        clk_bit(1'b1, v);
        ack = ~v;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, v);
            d[i] = v;
        end
        clk_bit(~mack, v);
    endtask

    task automatic do_write(input logic [15:0] a, input int n, input logic wp);
        logic ack;
        logic [7:0] d;
        logic [15:0] p;
        int c0;
        c0 = commits;
        p = a;
        wp_i = wp;
        bus_start();
        send_byte(SEL_W, ack);   check("R3 select ack", ack, 1);
        send_byte(a[15:8], ack); check("R4 addr hi ack", ack, 1);
        send_byte(a[7:0], ack);  check("R4 addr lo ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            send_byte(d, ack);
            if (wp) check("R6 data nack", ack, 0);
            else begin
                check("R5 data ack", ack, 1);
                exp_mem[int'(p)] = d;
                p = {p[15:7], p[6:0] + 7'd1};
            end
        end
        bus_stop();
        wait_q();
        check("R7 commit count", commits - c0, (!wp && n > 0) ? 1 : 0);
        exp_addr = p;
        wp_i = 1'b0;
    endtask

    task automatic read_body(input int n, input string r);
        logic [7:0] d;
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, d);
            check(r, d, get_exp(exp_addr));
            exp_addr = exp_addr + 16'd1;
        end
    endtask

    task automatic do_read_rand(input logic [15:0] a, input int n);
        logic ack;
        bus_start();
        send_byte(SEL_W, ack);   check("R3 select ack", ack, 1);
        send_byte(a[15:8], ack); check("R4 addr hi ack", ack, 1);
        send_byte(a[7:0], ack);  check("R4 addr lo ack", ack, 1);
        bus_start();
        send_byte(SEL_R, ack);   check("R3 read select ack", ack, 1);
        exp_addr = a;
        read_body(n, "R8 read data");
        bus_stop();
    endtask

    task automatic do_read_cur(input int n, input string r);
        logic ack;
        bus_start();
        send_byte(SEL_R, ack); check("R3 read select ack", ack, 1);
        read_body(n, r);
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ack, v;
        logic [7:0] d;
        int c0;
        void'($urandom(32'd2718));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 oe after reset", sda_oe_o, 0);
        check("R1 strobes after reset", {wr_en_o, wr_commit_o, rd_req_o}, 0);

        // R3 wrong type code, then later bytes ignored
        bus_start();
        send_byte(8'hBA, ack); check("R3 wrong type nack", ack, 0);
        send_byte(8'h00, ack); check("R3 ignored after mismatch", ack, 0);
        bus_stop();
        // R3 wrong strap
        bus_start();
        send_byte(8'hA8, ack); check("R3 wrong strap nack", ack, 0);
        bus_stop();

        // R4 R5 byte write and random read back
        do_write(16'h1234, 1, 1'b0);
        do_read_rand(16'h1234, 1);

        // R5 page wrap: 0x0A7E..0x0A01
        do_write(16'h0A7E, 4, 1'b0);
        check("R5 page wrap target", get_dut(16'h0A00), get_exp(16'h0A00));
        check("R5 next page untouched", get_dut(16'h0A80), dflt(16'h0A80));
        // R9 current address after wrap continues at 0x0A02
        do_read_cur(2, "R9 current address read");
        // R8 sequential read crosses page linearly
        do_read_rand(16'h0A7E, 4);

        // R6 write protect
        do_write(16'h0A00, 3, 1'b1);
        check("R6 memory unchanged", get_dut(16'h0A00), get_exp(16'h0A00));
        do_read_cur(1, "R6 address not advanced");

        // R8 master nack -> standby, bus released
        do_read_rand(16'h1234, 1);
        bus_start();
        send_byte(SEL_R, ack); check("R8 read select ack", ack, 1);
        recv_byte(1'b0, d);
        check("R8 nack byte", d, get_exp(exp_addr));
        exp_addr = exp_addr + 16'd1;
        recv_byte(1'b0, d);
        check("R8 released after nack", d, 8'hFF);
        bus_stop();

        // R2 START in the middle of a byte aborts it
        bus_start();
        clk_bit(1'b1, v); clk_bit(1'b0, v); clk_bit(1'b1, v); clk_bit(1'b1, v);
        do_read_cur(1, "R2 read after aborted byte");

        // R10 busy: no ack, no strobes
        busy_i = 1'b1;
        c0 = commits;
        bus_start();
        send_byte(SEL_W, ack); check("R10 busy nack", ack, 0);
        send_byte(8'h00, ack); check("R10 busy stays quiet", ack, 0);
        bus_stop();
        busy_i = 1'b0;
        wait_q();
        check("R10 no commit while busy", commits - c0, 0);
        do_read_cur(1, "R10 recovers after busy");

        // constrained random write / read-back
        for (int it = 0; it < 12; it++) begin
            logic [15:0] a;
            int n;
            logic wp;
            a  = 16'($urandom);
            n  = 1 + int'($urandom % 5);
            wp = (($urandom % 4) == 0);
            do_write(a, n, wp);
            do_read_rand(a, n + 1);
        end

        check("R11 oe changed with clock high", oe_bad, 0);

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule